// File: doc/BRIEF.md
# Content-Independent Frame Stripping Controller

This block sits in the receive path of a token-ring MAC. For every frame that arrives it decides whether the station strips the frame off the ring or repeats it downstream. The decision does not depend on the frame's source address matching the station, so a station that forwards frames carrying other stations' addresses can still remove its own traffic. The decision rests on a local count of frames that the station has put on the ring and that have not yet come back.

While the station holds the token, each frame it transmits raises the count. Before releasing the token it sends one minimum-size void frame that carries its own source address; that frame acts as the end marker of the epoch. On receive, a nonzero count means the frame is stripped, and each stripped frame that arrives error-free lowers the count. When the self-addressed void frame returns error-free, the count is forced to zero whatever its value.

Frame parsing, CRC checking and the symbol path are outside the block. They arrive as single-cycle strobes. The decision is registered one cycle after the source address has been parsed. That leaves the surrounding datapath time to cut the frame short, so any remnant stays below the 17-byte minimum frame size.

Top module: `frame_strip_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the outstanding count to zero, drops any latched decision (`strip_valid`=0, `strip`=0) and leaves the transmit side not holding the token.
- R2: After `tx_token_captured`, each `tx_frame_sent` pulse raises the outstanding count by one. A `tx_frame_sent` pulse while the token is not held has no effect on the count.
- R3: The count saturates at 2**CNT_W-1 on increment. The default CNT_W of 10 covers at least 560 outstanding frames.
- R4: A `rx_sa_valid` pulse inside a frame latches a decision. From the next cycle `strip_valid` is 1 and `strip` holds the decision. Both stay stable through the cycle in which `rx_frame_end` is high, and both are 0 in the cycle after it.
- R5: The decision is strip (`strip`=1) when the count is nonzero or `rx_sa_own` is 1. It is repeat (`strip`=0) when the count is zero and the source address is not the station's own.
- R6: At the end of a stripped frame with `rx_error_free`=1 the count falls by one. A stripped frame with `rx_error_free`=0 and any repeated frame leave the count unchanged.
- R7: The count saturates at zero on decrement. A stripped own-address frame received while the count is zero leaves it at zero.
- R8: A frame ending with `rx_error_free`=1, `rx_is_void`=1 and a latched own source address forces the count to zero. An errored own void frame leaves the count unchanged. A void frame from another address is treated like any other frame.
- R9: After `tx_void_sent`, further `tx_frame_sent` pulses are ignored until the next `tx_token_captured`. After `tx_token_sent`, they are ignored until the next capture.
- R10: A frame that ends before its source address is parsed produces no decision (`strip_valid` stays 0) and leaves the count unchanged.
- R11: `rx_sa_valid` outside a frame is ignored. A `rx_frame_start` inside a frame drops the earlier decision without touching the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_token_captured | input | 1 | Pulse: station captured the token |
| tx_frame_sent | input | 1 | Pulse: station transmitted a data frame |
| tx_void_sent | input | 1 | Pulse: station transmitted its closing void frame |
| tx_token_sent | input | 1 | Pulse: station released the token |
| rx_frame_start | input | 1 | Pulse: start of a received frame |
| rx_sa_valid | input | 1 | Pulse: source address of the current frame parsed |
| rx_sa_own | input | 1 | Source address equals the station address, qualified by rx_sa_valid |
| rx_frame_end | input | 1 | Pulse: end of the received frame |
| rx_error_free | input | 1 | Frame received without error, qualified by rx_frame_end |
| rx_is_void | input | 1 | Frame is a void frame, qualified by rx_frame_end |
| strip | output | 1 | Latched decision: 1 strip, 0 repeat |
| strip_valid | output | 1 | A decision is held for the current frame |

## Verification
The bench builds the block with CNT_W set to 3, so the count tops out at 7. Loading epochs of 0 to 9 frames therefore reaches both saturation and the zero floor within a few hundred cycles. The count is read back only through the ports: error-free foreign frames are fed in until one is repeated, and the number stripped before that equals the count. With so small a counter, every error, void and own-address combination can be tried against a known starting count.

// File: rtl/frame_strip_pkg.sv
package frame_strip_pkg;

  // Transmit-side token ownership phases.
  typedef enum logic [1:0] {
    HOLD_IDLE  = 2'd0,  // token not held, transmissions not counted
    HOLD_COUNT = 2'd1,  // token held, data frames counted
    HOLD_CLOSE = 2'd2   // void frame sent, awaiting token release
  } hold_state_e;

  // Decision latched per received frame.
  typedef struct packed {
    logic valid;  // decision taken for the current frame
    logic strip;  // 1: strip, 0: repeat
    logic own;    // source address matched the station
  } decision_t;

  // Saturating step of the outstanding count. Simultaneous up and down
  // cancel out.
  function automatic logic [31:0] step_count(input logic [31:0] cur,
                                             input logic [31:0] lim,
                                             input logic        up,
                                             input logic        down);
    if (up && !down) begin
      return (cur >= lim) ? lim : cur + 32'd1;
    end else if (down && !up) begin
      return (cur == 32'd0) ? 32'd0 : cur - 32'd1;
    end
    return cur;
  endfunction

  // Strip rule at source-address time.
  function automatic logic decide_strip(input logic cnt_nonzero,
                                        input logic sa_own);
    return cnt_nonzero || sa_own;
  endfunction

endpackage

// File: rtl/fsc_token_tracker.sv
module fsc_token_tracker
  import frame_strip_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tok_capt,
  input  logic tok_sent,
  input  logic void_sent,
  input  logic frame_sent,
  output logic count_inc,
  output logic holding
);

  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (tok_sent) begin
      state_d = HOLD_IDLE;
    end else if (tok_capt) begin
      state_d = HOLD_COUNT;
    end else if (void_sent && state_q == HOLD_COUNT) begin
      state_d = HOLD_CLOSE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HOLD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign holding   = (state_q == HOLD_COUNT);
  assign count_inc = frame_sent && holding;

endmodule

// File: rtl/fsc_out_counter.sv
module fsc_out_counter
  import frame_strip_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             nonzero
);

  localparam logic [31:0] LIMIT = (32'd1 << CNT_W) - 32'd1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [31:0]      stepped;

  always_comb begin
    stepped = step_count(32'(cnt_q), LIMIT, inc, dec);
    cnt_d   = clr ? '0 : stepped[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt     = cnt_q;
  assign nonzero = |cnt_q;

endmodule

// File: rtl/fsc_rx_decider.sv
module fsc_rx_decider
  import frame_strip_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic sa_valid,
  input  logic sa_own,
  input  logic frame_end,
  input  logic error_free,
  input  logic is_void,
  input  logic cnt_nonzero,
  output logic sa_take,
  output logic cnt_dec,
  output logic cnt_clr,
  output logic strip,
  output logic strip_valid
);

  logic      in_frame_q;
  decision_t dec_q;
  logic      end_take;

  // Only the first parsed address of an open frame is used.
  assign sa_take  = sa_valid && in_frame_q && !dec_q.valid &&
                    !frame_start && !frame_end;
  assign end_take = frame_end && dec_q.valid;
  assign cnt_clr  = end_take && error_free && is_void && dec_q.own;
  assign cnt_dec  = end_take && error_free && dec_q.strip && !cnt_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      dec_q      <= '0;
    end else if (frame_start) begin
      in_frame_q <= 1'b1;
      dec_q      <= '0;
    end else if (frame_end) begin
      in_frame_q <= 1'b0;
      dec_q      <= '0;
    end else if (sa_take) begin
      dec_q.valid <= 1'b1;
      dec_q.strip <= decide_strip(cnt_nonzero, sa_own);
      dec_q.own   <= sa_own;
    end
  end

  assign strip       = dec_q.strip;
  assign strip_valid = dec_q.valid;

endmodule

// File: rtl/frame_strip_ctrl.sv
module frame_strip_ctrl
  import frame_strip_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_token_captured,
  input  logic tx_frame_sent,
  input  logic tx_void_sent,
  input  logic tx_token_sent,
  input  logic rx_frame_start,
  input  logic rx_sa_valid,
  input  logic rx_sa_own,
  input  logic rx_frame_end,
  input  logic rx_error_free,
  input  logic rx_is_void,
  output logic strip,
  output logic strip_valid
);

  // Named internal events, observed by the bound checker.
  logic             cnt_inc;
  logic             cnt_dec;
  logic             cnt_clr;
  logic             cnt_nonzero;
  logic             holding;
  logic             sa_take;
  logic [CNT_W-1:0] cnt_q;

  fsc_token_tracker u_tx (
    .clk        (clk),
    .rst        (rst),
    .tok_capt   (tx_token_captured),
    .tok_sent   (tx_token_sent),
    .void_sent  (tx_void_sent),
    .frame_sent (tx_frame_sent),
    .count_inc  (cnt_inc),
    .holding    (holding)
  );

  fsc_out_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (cnt_inc),
    .dec     (cnt_dec),
    .clr     (cnt_clr),
    .cnt     (cnt_q),
    .nonzero (cnt_nonzero)
  );

  fsc_rx_decider u_rx (
    .clk         (clk),
    .rst         (rst),
    .frame_start (rx_frame_start),
    .sa_valid    (rx_sa_valid),
    .sa_own      (rx_sa_own),
    .frame_end   (rx_frame_end),
    .error_free  (rx_error_free),
    .is_void     (rx_is_void),
    .cnt_nonzero (cnt_nonzero),
    .sa_take     (sa_take),
    .cnt_dec     (cnt_dec),
    .cnt_clr     (cnt_clr),
    .strip       (strip),
    .strip_valid (strip_valid)
  );

endmodule

// File: rtl/frame_strip_ctrl_chk.sv
module frame_strip_ctrl_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_frame_start,
  input logic             rx_frame_end,
  input logic             rx_sa_own,
  input logic             strip,
  input logic             strip_valid,
  input logic             cnt_inc,
  input logic             cnt_dec,
  input logic             cnt_clr,
  input logic             cnt_nonzero,
  input logic             holding,
  input logic             sa_take,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  // R3: increment at the top leaves the count there
  p_sat_top_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_inc && !cnt_dec && !cnt_clr && cnt == CMAX |=> cnt == CMAX);

  // R7: decrement at zero leaves the count at zero
  p_floor_zero_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_dec && !cnt_inc && !cnt_clr && cnt == '0 |=> cnt == '0);

  // R5: nonzero count at address time yields a strip decision
  p_strip_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    sa_take && cnt_nonzero |=> strip_valid && strip);

  // R5: own address always yields a strip decision
  p_strip_own_r5: assert property (@(posedge clk) disable iff (rst)
    sa_take && rx_sa_own |=> strip_valid && strip);

  // R4: decision held stable while the frame is open
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    strip_valid && !rx_frame_end && !rx_frame_start |=> strip_valid && $stable(strip));

  // R4: decision released after the frame end
  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    rx_frame_end && !rx_frame_start |=> !strip_valid);

  // R8: own error-free void clears the count
  p_void_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> cnt == '0);

  // R2/R9: without the token held, only receive events move the count
  p_idle_static_r9: assert property (@(posedge clk) disable iff (rst)
    !holding && !cnt_dec && !cnt_clr |=> cnt == $past(cnt));

endmodule

bind frame_strip_ctrl frame_strip_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rx_frame_start (rx_frame_start),
  .rx_frame_end   (rx_frame_end),
  .rx_sa_own      (rx_sa_own),
  .strip          (strip),
  .strip_valid    (strip_valid),
  .cnt_inc        (cnt_inc),
  .cnt_dec        (cnt_dec),
  .cnt_clr        (cnt_clr),
  .cnt_nonzero    (cnt_nonzero),
  .holding        (holding),
  .sa_take        (sa_take),
  .cnt            (cnt_q)
);

// File: tb/frame_strip_ctrl_tb.sv
module frame_strip_ctrl_tb;

  localparam int CW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_capt = 0, frm_sent = 0, void_sent = 0, tok_sent = 0;
  logic f_start = 0, sa_v = 0, sa_own = 0, f_end = 0, ef = 0, is_void = 0;
  logic strip, strip_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  frame_strip_ctrl #(.CNT_W(CW)) u_dut (
    .clk               (clk),
    .rst               (rst),
    .tx_token_captured (tok_capt),
    .tx_frame_sent     (frm_sent),
    .tx_void_sent      (void_sent),
    .tx_token_sent     (tok_sent),
    .rx_frame_start    (f_start),
    .rx_sa_valid       (sa_v),
    .rx_sa_own         (sa_own),
    .rx_frame_end      (f_end),
    .rx_error_free     (ef),
    .rx_is_void        (is_void),
    .strip             (strip),
    .strip_valid       (strip_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tx(input int which);
    @(negedge clk);
    tok_capt  = (which == 0);
    frm_sent  = (which == 1);
    void_sent = (which == 2);
    tok_sent  = (which == 3);
    @(negedge clk);
    tok_capt = 0; frm_sent = 0; void_sent = 0; tok_sent = 0;
  endtask

  // Full epoch: capture, n data frames, void frame, token release.
  task automatic load(input int n);
    pulse_tx(0);
    for (int i = 0; i < n; i++) pulse_tx(1);
    pulse_tx(2);
    pulse_tx(3);
  endtask

  // Receive one frame; return the decision seen after address parse.
  task automatic rx_frame(input logic own, input logic e_free, input logic vd,
                          output logic s, output logic v);
    @(negedge clk);
    f_start = 1;
    @(negedge clk);
    f_start = 0; sa_v = 1; sa_own = own;
    @(negedge clk);
    sa_v = 0; sa_own = 0;
    s = strip; v = strip_valid;
    @(negedge clk);
    f_end = 1; ef = e_free; is_void = vd;
    @(negedge clk);
    f_end = 0; ef = 0; is_void = 0;
  endtask

  // Drain the count with error-free foreign frames; number stripped = count.
  task automatic measure(output int n);
    logic s, v;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      rx_frame(1'b0, 1'b1, 1'b0, s, v);
      if (!v) begin
        n = -1;
        break;
      end
      if (s) n++;
      else break;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic s, v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    chk("R1 strip_valid", strip_valid, 0);
    chk("R1 strip", strip, 0);
    pulse_tx(1);
    measure(n);
    chk("R1 count after reset, not holding", n, 0);

    // R2 R3 R5 R6 R7: sweep of epoch sizes beyond saturation
    for (int k = 0; k <= CMAX + 2; k++) begin
      load(k);
      measure(n);
      chk(k > CMAX ? "R3 saturated count" : "R2 count per frame", n,
          k > CMAX ? CMAX : k);
      rx_frame(1'b0, 1'b1, 1'b0, s, v);
      chk("R7 repeat after drain", s, 0);
      chk("R5 decision valid", v, 1);
    end

    // R6: errored stripped frames leave count
    load(3);
    rx_frame(1'b0, 1'b0, 1'b0, s, v);
    chk("R6 errored frame stripped", s, 1);
    rx_frame(1'b0, 1'b0, 1'b0, s, v);
    measure(n);
    chk("R6 errored frames no decrement", n, 3);

    // R7: own frame at zero is stripped and count stays zero
    rx_frame(1'b1, 1'b1, 1'b0, s, v);
    chk("R7 own frame at zero stripped", s, 1);
    measure(n);
    chk("R7 floor at zero", n, 0);

    // R8: own error-free void clears the count
    load(5);
    rx_frame(1'b1, 1'b1, 1'b1, s, v);
    chk("R8 own void stripped", s, 1);
    measure(n);
    chk("R8 own void clears", n, 0);

    // R8: errored own void leaves count
    load(4);
    rx_frame(1'b1, 1'b0, 1'b1, s, v);
    measure(n);
    chk("R8 errored own void", n, 4);

    // R8: foreign void acts like an ordinary frame
    load(4);
    rx_frame(1'b0, 1'b1, 1'b1, s, v);
    chk("R8 foreign void stripped", s, 1);
    measure(n);
    chk("R8 foreign void decrements", n, 3);

    // R9: frames after void and after token release not counted
    pulse_tx(0);
    pulse_tx(1);
    pulse_tx(1);
    pulse_tx(2);
    pulse_tx(1);
    pulse_tx(1);
    pulse_tx(3);
    pulse_tx(1);
    measure(n);
    chk("R9 counting stops at void and release", n, 2);

    // R2: frames with no capture are ignored
    pulse_tx(1);
    pulse_tx(1);
    measure(n);
    chk("R2 no count without token", n, 0);

    // R10: fragment without address gives no decision, count unchanged
    load(2);
    @(negedge clk); f_start = 1;
    @(negedge clk); f_start = 0;
    @(negedge clk);
    chk("R10 no decision in fragment", strip_valid, 0);
    f_end = 1; ef = 1;
    @(negedge clk); f_end = 0; ef = 0;
    measure(n);
    chk("R10 fragment leaves count", n, 2);

    // R11: address strobe outside a frame ignored
    @(negedge clk); sa_v = 1; sa_own = 1;
    @(negedge clk); sa_v = 0; sa_own = 0;
    @(negedge clk);
    chk("R11 stray address ignored", strip_valid, 0);

    // R4 R11: hold through frame, release after end, restart drops decision
    load(1);
    @(negedge clk); f_start = 1;
    @(negedge clk); f_start = 0; sa_v = 1;
    chk("R4 not valid before edge", strip_valid, 0);
    @(negedge clk); sa_v = 0;
    chk("R4 valid cycle after address", strip_valid, 1);
    @(negedge clk);
    @(negedge clk);
    chk("R4 held strip", strip, 1);
    f_start = 1;
    @(negedge clk); f_start = 0;
    chk("R11 restart drops decision", strip_valid, 0);
    sa_v = 1;
    @(negedge clk); sa_v = 0;
    chk("R11 count untouched by restart", strip, 1);
    f_end = 1; ef = 1;
    chk("R4 held in end cycle", strip_valid, 1);
    @(negedge clk); f_end = 0; ef = 0;
    chk("R4 released after end", strip_valid, 0);
    measure(n);
    chk("R6 single decrement", n, 0);

    // R1: mid-epoch reset clears count and holding
    pulse_tx(0);
    pulse_tx(1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    pulse_tx(1);
    measure(n);
    chk("R1 reset clears count and token", n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule